// File: doc/BRIEF.md
# Sticky Condition Predicate Evaluator

This block turns the four arithmetic flags (negative, zero, carry, overflow) into one yes/no answer for a chosen condition test. A compare instruction presents a 4-bit test code together with a strobe. On that clock edge the answer of the test is captured in one dedicated condition bit. The bit then holds its value until the next compare, however many flag-setting instructions run in between.

Each ordinary instruction carries a small predicate select. It chooses whether the instruction always runs, never runs, runs on the held condition bit or its inverse, or runs on the live zero or carry flag. The block gives the combinational answer of the current test, the held condition bit and the resulting execute enable. The flag producer and the pipeline that issues instructions sit outside this block.

Top module: `cond_pred_unit`

## Requirements
- R1: The flag input packs negative in bit 3, zero in bit 2, carry in bit 1 and overflow in bit 0. Test codes 0 to 7 give, in order: zero set, zero clear, carry set, carry clear, negative set, negative clear, overflow set, overflow clear.
- R2: Code 8 (unsigned higher) is true when carry is set and zero is clear. Code 9 (unsigned lower-or-same) is true when carry is clear or zero is set.
- R3: Code 10 (signed greater-or-equal) is true when negative equals overflow. Code 11 (signed less-than) is true when they differ.
- R4: Code 12 (signed greater-than) is true when zero is clear and negative equals overflow. Code 13 (signed less-or-equal) is true when zero is set or negative differs from overflow.
- R5: Code 14 is true for every flag value. Code 15 is false for every flag value.
- R6: The held condition bit is 0 while reset is asserted and just after reset is released.
- R7: On a clock edge with the compare strobe high, the held bit takes the live result of the current test code and flags. The new value is visible from the next cycle on.
- R8: On edges with the strobe low, the held bit does not change, whatever the flags and test code do.
- R9: Predicate select 0 enables execution always. Select 1 enables it when the held bit is 1. Select 2 enables it when the held bit is 0.
- R10: Predicate selects 3 and 4 enable execution on live zero set and zero clear. Selects 5 and 6 enable it on live carry set and carry clear.
- R11: Predicate select 7 never enables execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flags_i | input | 4 | Live flags {N, Z, C, V} |
| cond_sel_i | input | 4 | Test code carried by a compare |
| cmp_strobe_i | input | 1 | Compare strobe; loads the held bit |
| pred_sel_i | input | 3 | Predicate select of the issuing instruction |
| cond_live_o | output | 1 | Combinational result of the selected test |
| cond_flag_o | output | 1 | Held condition bit |
| exec_en_o | output | 1 | Execute enable for the issuing instruction |

## Verification
The only internal state is the held condition bit. If it is wrong, two ports show it in the cycle after the faulty edge. The bit appears directly on cond_flag_o, and exec_en_o inverts under predicate selects 1 and 2. A load that fails, or a hold that leaks, therefore shows up one cycle after the compare strobe or the flag change that caused it. A wrong test decode shows on cond_live_o in the same cycle and is caught by a sweep of all 256 code and flag pairs.

// File: rtl/cond_pred_pkg.sv
package cond_pred_pkg;

   localparam int unsigned COND_W = 4;
   localparam int unsigned PSEL_W = 3;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef enum logic [COND_W-1:0] {
      CC_EQ  = 4'd0,  CC_NE  = 4'd1,  CC_HS  = 4'd2,  CC_LO  = 4'd3,
      CC_MI  = 4'd4,  CC_PL  = 4'd5,  CC_VS  = 4'd6,  CC_VC  = 4'd7,
      CC_HI  = 4'd8,  CC_LS  = 4'd9,  CC_GE  = 4'd10, CC_LT  = 4'd11,
      CC_GT  = 4'd12, CC_LE  = 4'd13, CC_AL  = 4'd14, CC_RSV = 4'd15
   } cc_t;

   typedef enum logic [PSEL_W-1:0] {
      PS_ALWAYS = 3'd0, PS_COND = 3'd1, PS_NCOND = 3'd2, PS_ZSET = 3'd3,
      PS_ZCLR   = 3'd4, PS_CSET = 3'd5, PS_CCLR  = 3'd6, PS_NEVER = 3'd7
   } psel_t;

   function automatic logic cc_test(input logic [COND_W-1:0] code, input flags_t f);
      logic sgn_ok;
      sgn_ok = (f.n == f.v);
      case (cc_t'(code))
         CC_EQ:   cc_test = f.z;
         CC_NE:   cc_test = !f.z;
         CC_HS:   cc_test = f.c;
         CC_LO:   cc_test = !f.c;
         CC_MI:   cc_test = f.n;
         CC_PL:   cc_test = !f.n;
         CC_VS:   cc_test = f.v;
         CC_VC:   cc_test = !f.v;
         CC_HI:   cc_test = f.c && !f.z;
         CC_LS:   cc_test = !f.c || f.z;
         CC_GE:   cc_test = sgn_ok;
         CC_LT:   cc_test = !sgn_ok;
         CC_GT:   cc_test = !f.z && sgn_ok;
         CC_LE:   cc_test = f.z || !sgn_ok;
         CC_AL:   cc_test = 1'b1;
         default: cc_test = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
   import cond_pred_pkg::*;
#(
   parameter int unsigned SEL_W = COND_W
) (
   input  flags_t           flags,
   input  logic [SEL_W-1:0] sel,
   output logic             result
);
   localparam int unsigned NCODES = 1 << SEL_W;

   if (SEL_W != COND_W) begin : g_bad_width
      $error("cond_eval: SEL_W must equal COND_W");
   end

   logic [NCODES-1:0] all_res;

   for (genvar i = 0; i < NCODES; i++) begin : g_code
      assign all_res[i] = cc_test(SEL_W'(i), flags);
   end

   assign result = all_res[sel];

endmodule

// File: rtl/cond_sticky.sv
module cond_sticky #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (load) q <= d;
   end

   AST_STICKY_RESET: assert property (@(posedge clk) !rst_n |=> (q == RESET_VAL)); // R6
   AST_STICKY_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                                      !load |=> $stable(q)); // R8
   AST_STICKY_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
                                      load |=> (q == $past(d))); // R7

endmodule

// File: rtl/exec_gate.sv
module exec_gate
   import cond_pred_pkg::*;
#(
   parameter int unsigned PW = PSEL_W
) (
   input  logic [PW-1:0] psel,
   input  logic          cond,
   input  flags_t        flags,
   output logic          en
);
   localparam int unsigned NSEL = 1 << PW;

   if (PW != PSEL_W) begin : g_bad_width
      $error("exec_gate: PW must equal PSEL_W");
   end

   logic [NSEL-1:0] cand;

   always_comb begin
      cand = '0;
      cand[PS_ALWAYS] = 1'b1;
      cand[PS_COND]   = cond;
      cand[PS_NCOND]  = !cond;
      cand[PS_ZSET]   = flags.z;
      cand[PS_ZCLR]   = !flags.z;
      cand[PS_CSET]   = flags.c;
      cand[PS_CCLR]   = !flags.c;
      cand[PS_NEVER]  = 1'b0;
   end

   assign en = cand[psel];

endmodule

// File: rtl/cond_pred_unit.sv
module cond_pred_unit
   import cond_pred_pkg::*;
#(
   parameter int unsigned SEL_W     = COND_W,
   parameter int unsigned PW        = PSEL_W,
   parameter logic        RESET_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       flags_i,
   input  logic [SEL_W-1:0] cond_sel_i,
   input  logic             cmp_strobe_i,
   input  logic [PW-1:0]    pred_sel_i,
   output logic             cond_live_o,
   output logic             cond_flag_o,
   output logic             exec_en_o
);
   flags_t fl;
   assign fl = flags_t'(flags_i);

   cond_eval #(.SEL_W(SEL_W)) u_eval (
      .flags  (fl),
      .sel    (cond_sel_i),
      .result (cond_live_o)
   );

   cond_sticky #(.RESET_VAL(RESET_VAL)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cmp_strobe_i),
      .d     (cond_live_o),
      .q     (cond_flag_o)
   );

   exec_gate #(.PW(PW)) u_gate (
      .psel  (pred_sel_i),
      .cond  (cond_flag_o),
      .flags (fl),
      .en    (exec_en_o)
   );

   AST_AL_TRUE:     assert property (@(posedge clk) disable iff (!rst_n)
                                     (cond_sel_i == SEL_W'(CC_AL)) |-> cond_live_o); // R5
   AST_RSV_FALSE:   assert property (@(posedge clk) disable iff (!rst_n)
                                     (cond_sel_i == SEL_W'(CC_RSV)) |-> !cond_live_o); // R5
   AST_EXEC_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
                                     (pred_sel_i == PW'(PS_ALWAYS)) |-> exec_en_o); // R9
   AST_EXEC_COND:   assert property (@(posedge clk) disable iff (!rst_n)
                                     (pred_sel_i == PW'(PS_COND)) |-> (exec_en_o == cond_flag_o)); // R9
   AST_EXEC_NEVER:  assert property (@(posedge clk) disable iff (!rst_n)
                                     (pred_sel_i == PW'(PS_NEVER)) |-> !exec_en_o); // R11

endmodule

// File: tb/cond_pred_unit_tb.sv
module cond_pred_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] flags_i;
   logic [3:0] cond_sel_i;
   logic       cmp_strobe_i;
   logic [2:0] pred_sel_i;
   logic       cond_live_o;
   logic       cond_flag_o;
   logic       exec_en_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cond_pred_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .flags_i      (flags_i),
      .cond_sel_i   (cond_sel_i),
      .cmp_strobe_i (cmp_strobe_i),
      .pred_sel_i   (pred_sel_i),
      .cond_live_o  (cond_live_o),
      .cond_flag_o  (cond_flag_o),
      .exec_en_o    (exec_en_o)
   );

   function automatic logic ref_cond(input int code, input logic [3:0] f);
      logic n, z, c, v;
      {n, z, c, v} = f;
      case (code)
         0: return z;          1: return !z;
         2: return c;          3: return !c;
         4: return n;          5: return !n;
         6: return v;          7: return !v;
         8: return c & ~z;     9: return ~c | z;
         10: return ~(n ^ v);  11: return n ^ v;
         12: return ~z & ~(n ^ v);
         13: return z | (n ^ v);
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input int code);
      if (code < 8)       return "R1";
      else if (code < 10) return "R2";
      else if (code < 12) return "R3";
      else if (code < 14) return "R4";
      return "R5";
   endfunction

   function automatic logic ref_exec(input int p, input logic s, input logic [3:0] f);
      case (p)
         0: return 1'b1;   1: return s;    2: return !s;
         3: return f[2];   4: return !f[2];
         5: return f[1];   6: return !f[1];
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic load_flag(input logic val);
      @(negedge clk);
      cond_sel_i   = val ? 4'd14 : 4'd15;
      cmp_strobe_i = 1'b1;
      @(posedge clk);
      #1;
      cmp_strobe_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flags_i = '0; cond_sel_i = '0; cmp_strobe_i = 1'b0; pred_sel_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6", "flag in reset", cond_flag_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6", "flag after reset", cond_flag_o, 1'b0);

      // R1..R5: exhaustive live decode
      for (int code = 0; code < 16; code++) begin
         for (int f = 0; f < 16; f++) begin
            @(negedge clk);
            cond_sel_i = 4'(code); flags_i = 4'(f);
            #1;
            check(req_of(code), $sformatf("live code %0d flags %h", code, f),
                  cond_live_o, ref_cond(code, 4'(f)));
         end
      end

      // R7: every compare loads its own result, seen next cycle
      for (int code = 0; code < 16; code++) begin
         for (int f = 0; f < 16; f++) begin
            @(negedge clk);
            cond_sel_i = 4'(code); flags_i = 4'(f); cmp_strobe_i = 1'b1;
            @(posedge clk);
            #1;
            check("R7", $sformatf("load code %0d flags %h", code, f),
                  cond_flag_o, ref_cond(code, 4'(f)));
         end
      end
      cmp_strobe_i = 1'b0;

      // R8: held bit survives flag and code changes without strobe
      for (int s = 0; s < 2; s++) begin
         load_flag(1'(s));
         for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f += 5) begin
               @(negedge clk);
               cond_sel_i = 4'(code); flags_i = 4'(f);
               @(posedge clk);
               #1;
               check("R8", $sformatf("hold code %0d flags %h", code, f), cond_flag_o, 1'(s));
            end
         end
      end

      // R9, R10, R11: execute enable over all selects
      for (int s = 0; s < 2; s++) begin
         load_flag(1'(s));
         for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 16; f++) begin
               @(negedge clk);
               pred_sel_i = 3'(p); flags_i = 4'(f);
               #1;
               check(p < 3 ? "R9" : (p < 7 ? "R10" : "R11"),
                     $sformatf("exec sel %0d held %0d flags %h", p, s, f),
                     exec_en_o, ref_exec(p, 1'(s), 4'(f)));
            end
         end
      end

      // R6: reset in mid-run clears a held 1
      load_flag(1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R6", "flag after re-reset", cond_flag_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6", "flag after release", cond_flag_o, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule